// File: doc/BRIEF.md
# Standby CEC Wake-Up Message Filter

This block runs while the rest of the system is asleep. Upstream, a bit-level receiver assembles each CEC frame and presents it as one word: the header byte, the number of bytes that follow the header, the opcode, the first operand and a one-cycle valid strobe. The filter compares each frame against five programmable opcode slots. When an enabled slot accepts the frame, the filter sets a sticky wake-status bit for that slot. The wake request is the OR of those status bits.

Slot 2 also compares the first operand against two alternative values, and each of those compares has its own enable. Slot 4 can be marked broadcast-only. In that mode it accepts only a broadcast frame with exactly three bytes after the header.

The filter also chooses a canned reply for a transmitter to queue. Three inquiries addressed to the device have fixed answers: physical-address request, vendor-identifier request and version request. Any other directed opcode that no enabled slot knows gets a feature-abort reply. Configuration, the wake-status bits and their clearing all go through a byte-wide register port.

Top module: `cec_wake_filter`

## Requirements
- R1: After reset, the registers hold the following values. Enable mask (address 0x00) is 0x17, which enables slots 0, 1, 2 and 4. Control (0x01) is 0x70. Slot opcodes (0x02 to 0x06, for slots 0 to 4) are 0x04, 0x0D, 0x44, 0x00 and 0x82. Operand A (0x07) is 0x40 and operand B (0x08) is 0x6D. Vendor bytes (0x09 to 0x0B), physical address (0x0C to 0x0D) and device type (0x0F) are all 0. Misc (0x0E) is 0x29. Status (0x10) is 0. wake_o is low. Unmapped addresses read 0.
- R2: A frame sets status bit k one cycle after frm_valid_i when all of these hold: slot k is enabled, at least one byte follows the header, the opcode equals slot k's opcode, and the header's low nibble (destination) equals the own address. The own address is control bits [3:0]. This rule covers slots 0, 1 and 3, and slot 4 when it is not broadcast-only. A broadcast frame (destination 0xF) never sets bits 0 to 3.
- R3: Slot 2 also needs an operand match when control bit 4 (operand A enable) or bit 5 (operand B enable) is set. In that case there must be at least two bytes after the header, and the operand must equal an enabled alternative. With both enables clear, the opcode alone is enough.
- R4: When control bit 6 is set, slot 4 matches only a broadcast frame with exactly 3 bytes after the header. A directed frame carrying slot 4's opcode then does not set bit 4.
- R5: A disabled slot, a different destination or a zero-length frame leaves the status unchanged.
- R6: Status bits are sticky. Writing a 1 to a bit of address 0x10 clears it, and writing a 0 leaves it unchanged. When a frame sets a bit in the same cycle that a write clears it, the bit stays set.
- R7: wake_o is high exactly while any status bit is set, and it stays high until software clears the bits.
- R8: Some directed frames get a feature-abort reply: frames addressed to the own address, with at least one byte after the header, whose opcode is neither an inquiry nor the opcode of any enabled slot. The reply has kind 0, destination equal to the header's high nibble, and data {8'h00, opcode, 5'b0, reason}. The reason is misc bits [2:0].
- R9: A broadcast frame never produces any reply, including a feature abort.
- R10: A directed opcode 0x83 replies with kind 1, destination 0xF and data {physical address, device type}. Opcode 0x8C replies with kind 2, destination 0xF and data equal to the three vendor bytes, with address 0x09 as the most significant. Opcode 0x9F replies with kind 3, destination equal to the sender and data {16'h0, 5'b0, version}. The version is misc bits [5:3].
- R11: reply_valid_o is a single-cycle pulse, one cycle after the frame strobe. A frame with zero bytes after the header (a poll) produces no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from address |
| frm_valid_i | input | 1 | One-cycle strobe for a completed frame |
| frm_hdr_i | input | 8 | Header: sender [7:4], destination [3:0] |
| frm_len_i | input | 5 | Bytes after the header |
| frm_opcode_i | input | 8 | Opcode byte |
| frm_arg_i | input | 8 | First operand byte |
| wake_o | output | 1 | Level wake request |
| reply_valid_o | output | 1 | Reply selection pulse |
| reply_kind_o | output | 2 | 0 abort, 1 physical address, 2 vendor, 3 version |
| reply_dest_o | output | 4 | Reply destination address |
| reply_data_o | output | 24 | Reply payload |

## Verification
The assertions check five properties on every cycle:
- a status bit rises only one cycle after a frame strobe;
- a status bit falls only after a status write;
- bits 0 to 3 never rise from a broadcast frame;
- a broadcast hit on slot 4 always had three bytes after the header;
- replies never follow a broadcast frame or a poll.

Other behaviour only the bench's sweeps can show. That covers which exact opcodes, operands, destinations and lengths match; the priority between feature abort and slot or inquiry opcodes; the reply payloads; and the set-over-clear collision.

// File: rtl/cec_wake_pkg.sv
package cec_wake_pkg;
  localparam int NUM_SLOTS  = 5;
  localparam int ADDR_W     = 5;
  localparam int LEN_W      = 5;
  localparam int OPND_SLOT  = 2;
  localparam int BCAST_SLOT = 4;
  localparam int BCAST_LEN  = 3;
  localparam int REPLY_W    = 24;
  localparam logic [3:0] BCAST_LA = 4'hF;

  localparam logic [7:0] OP_GIVE_PHYS   = 8'h83;
  localparam logic [7:0] OP_GIVE_VENDOR = 8'h8C;
  localparam logic [7:0] OP_GET_VER     = 8'h9F;

  localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SLOT0 = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_ARG_A = ADDR_W'(2 + NUM_SLOTS);
  localparam logic [ADDR_W-1:0] A_ARG_B = ADDR_W'(3 + NUM_SLOTS);
  localparam logic [ADDR_W-1:0] A_VID0  = ADDR_W'(4 + NUM_SLOTS);
  localparam logic [ADDR_W-1:0] A_VID1  = ADDR_W'(5 + NUM_SLOTS);
  localparam logic [ADDR_W-1:0] A_VID2  = ADDR_W'(6 + NUM_SLOTS);
  localparam logic [ADDR_W-1:0] A_PA0   = ADDR_W'(7 + NUM_SLOTS);
  localparam logic [ADDR_W-1:0] A_PA1   = ADDR_W'(8 + NUM_SLOTS);
  localparam logic [ADDR_W-1:0] A_MISC  = ADDR_W'(9 + NUM_SLOTS);
  localparam logic [ADDR_W-1:0] A_TYPE  = ADDR_W'(10 + NUM_SLOTS);
  localparam logic [ADDR_W-1:0] A_STS   = ADDR_W'(11 + NUM_SLOTS);

  typedef enum logic [1:0] {
    RPL_ABORT   = 2'd0,
    RPL_PHYS    = 2'd1,
    RPL_VENDOR  = 2'd2,
    RPL_VERSION = 2'd3
  } reply_kind_e;

  typedef struct packed {
    logic [NUM_SLOTS-1:0]      slot_en;
    logic [3:0]                own_la;
    logic                      arg_a_en;
    logic                      arg_b_en;
    logic                      bcast_only;
    logic [NUM_SLOTS-1:0][7:0] slot_op;
    logic [7:0]                arg_a;
    logic [7:0]                arg_b;
    logic [23:0]               vid;
    logic [15:0]               pa;
    logic [2:0]                reason;
    logic [2:0]                version;
    logic [7:0]                dev_type;
  } cfg_t;

  localparam cfg_t CFG_RST = '{
    slot_en:    5'b10111,
    own_la:     4'h0,
    arg_a_en:   1'b1,
    arg_b_en:   1'b1,
    bcast_only: 1'b1,
    slot_op:    {8'h82, 8'h00, 8'h44, 8'h0D, 8'h04},
    arg_a:      8'h40,
    arg_b:      8'h6D,
    vid:        24'h0,
    pa:         16'h0,
    reason:     3'd1,
    version:    3'd5,
    dev_type:   8'h00
  };
endpackage

// File: rtl/cec_wake_regs.sv
module cec_wake_regs
  import cec_wake_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [7:0]           wdata_i,
  output logic [7:0]           rdata_o,
  input  logic [NUM_SLOTS-1:0] hit_i,
  output cfg_t                 cfg_o,
  output logic [NUM_SLOTS-1:0] sts_o
);
  cfg_t                 cfg_q;
  logic [NUM_SLOTS-1:0] sts_q;
  logic [NUM_SLOTS-1:0] clr;

  assign clr = (we_i && addr_i == A_STS) ? wdata_i[NUM_SLOTS-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
      sts_q <= '0;
    end else begin
      sts_q <= (sts_q & ~clr) | hit_i;  // set wins over clear
      if (we_i) begin
        case (addr_i)
          A_EN:    cfg_q.slot_en <= wdata_i[NUM_SLOTS-1:0];
          A_CTRL: begin
            cfg_q.own_la     <= wdata_i[3:0];
            cfg_q.arg_a_en   <= wdata_i[4];
            cfg_q.arg_b_en   <= wdata_i[5];
            cfg_q.bcast_only <= wdata_i[6];
          end
          A_ARG_A: cfg_q.arg_a         <= wdata_i;
          A_ARG_B: cfg_q.arg_b         <= wdata_i;
          A_VID0:  cfg_q.vid[23:16]    <= wdata_i;
          A_VID1:  cfg_q.vid[15:8]     <= wdata_i;
          A_VID2:  cfg_q.vid[7:0]      <= wdata_i;
          A_PA0:   cfg_q.pa[15:8]      <= wdata_i;
          A_PA1:   cfg_q.pa[7:0]       <= wdata_i;
          A_MISC: begin
            cfg_q.reason  <= wdata_i[2:0];
            cfg_q.version <= wdata_i[5:3];
          end
          A_TYPE:  cfg_q.dev_type      <= wdata_i;
          default: ;
        endcase
        for (int k = 0; k < NUM_SLOTS; k++) begin
          if (addr_i == ADDR_W'(A_SLOT0 + k)) cfg_q.slot_op[k] <= wdata_i;
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_EN:    rdata_o[NUM_SLOTS-1:0] = cfg_q.slot_en;
      A_CTRL:  rdata_o = {1'b0, cfg_q.bcast_only, cfg_q.arg_b_en, cfg_q.arg_a_en, cfg_q.own_la};
      A_ARG_A: rdata_o = cfg_q.arg_a;
      A_ARG_B: rdata_o = cfg_q.arg_b;
      A_VID0:  rdata_o = cfg_q.vid[23:16];
      A_VID1:  rdata_o = cfg_q.vid[15:8];
      A_VID2:  rdata_o = cfg_q.vid[7:0];
      A_PA0:   rdata_o = cfg_q.pa[15:8];
      A_PA1:   rdata_o = cfg_q.pa[7:0];
      A_MISC:  rdata_o = {2'b00, cfg_q.version, cfg_q.reason};
      A_TYPE:  rdata_o = cfg_q.dev_type;
      A_STS:   rdata_o[NUM_SLOTS-1:0] = sts_q;
      default: ;
    endcase
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (addr_i == ADDR_W'(A_SLOT0 + k)) rdata_o = cfg_q.slot_op[k];
    end
  end

  assign cfg_o = cfg_q;
  assign sts_o = sts_q;
endmodule

// File: rtl/cec_wake_match.sv
module cec_wake_match
  import cec_wake_pkg::*;
(
  input  cfg_t                 cfg_i,
  input  logic                 valid_i,
  input  logic [7:0]           hdr_i,
  input  logic [LEN_W-1:0]     len_i,
  input  logic [7:0]           opcode_i,
  input  logic [7:0]           arg_i,
  output logic                 to_me_o,
  output logic [NUM_SLOTS-1:0] op_known_o,
  output logic [NUM_SLOTS-1:0] hit_o
);
  logic bcast, has_op, arg_ok, arg_req;

  assign bcast   = hdr_i[3:0] == BCAST_LA;
  assign to_me_o = !bcast && hdr_i[3:0] == cfg_i.own_la;
  assign has_op  = len_i != '0;
  assign arg_req = cfg_i.arg_a_en || cfg_i.arg_b_en;
  assign arg_ok  = !arg_req ||
                   (len_i >= LEN_W'(2) &&
                    ((cfg_i.arg_a_en && arg_i == cfg_i.arg_a) ||
                     (cfg_i.arg_b_en && arg_i == cfg_i.arg_b)));

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic op_eq;
    assign op_eq         = cfg_i.slot_en[g] && has_op && opcode_i == cfg_i.slot_op[g];
    assign op_known_o[g] = op_eq;
    if (g == BCAST_SLOT) begin : g_bc
      assign hit_o[g] = valid_i && op_eq &&
                        (cfg_i.bcast_only ? (bcast && len_i == LEN_W'(BCAST_LEN)) : to_me_o);
    end else if (g == OPND_SLOT) begin : g_arg
      assign hit_o[g] = valid_i && op_eq && to_me_o && arg_ok;
    end else begin : g_plain
      assign hit_o[g] = valid_i && op_eq && to_me_o;
    end
  end
endmodule

// File: rtl/cec_wake_reply.sv
module cec_wake_reply
  import cec_wake_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  cfg_t               cfg_i,
  input  logic               valid_i,
  input  logic [7:0]         hdr_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [7:0]         opcode_i,
  input  logic               to_me_i,
  input  logic               op_known_i,
  output logic               valid_o,
  output logic [1:0]         kind_o,
  output logic [3:0]         dest_o,
  output logic [REPLY_W-1:0] data_o
);
  logic               req;
  reply_kind_e        kind;
  logic [3:0]         dest;
  logic [REPLY_W-1:0] data;

  always_comb begin
    req  = 1'b0;
    kind = RPL_ABORT;
    dest = hdr_i[7:4];
    data = {8'h00, opcode_i, 5'b0, cfg_i.reason};
    if (valid_i && to_me_i && len_i != '0) begin
      case (opcode_i)
        OP_GIVE_PHYS: begin
          req = 1'b1; kind = RPL_PHYS; dest = BCAST_LA;
          data = {cfg_i.pa, cfg_i.dev_type};
        end
        OP_GIVE_VENDOR: begin
          req = 1'b1; kind = RPL_VENDOR; dest = BCAST_LA;
          data = cfg_i.vid;
        end
        OP_GET_VER: begin
          req = 1'b1; kind = RPL_VERSION;
          data = {16'h0, 5'b0, cfg_i.version};
        end
        default: req = !op_known_i;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      kind_o  <= '0;
      dest_o  <= '0;
      data_o  <= '0;
    end else begin
      valid_o <= req;
      if (req) begin
        kind_o <= kind;
        dest_o <= dest;
        data_o <= data;
      end
    end
  end
endmodule

// File: rtl/cec_wake_filter.sv
module cec_wake_filter
  import cec_wake_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [7:0]         reg_wdata_i,
  output logic [7:0]         reg_rdata_o,
  input  logic               frm_valid_i,
  input  logic [7:0]         frm_hdr_i,
  input  logic [LEN_W-1:0]   frm_len_i,
  input  logic [7:0]         frm_opcode_i,
  input  logic [7:0]         frm_arg_i,
  output logic               wake_o,
  output logic               reply_valid_o,
  output logic [1:0]         reply_kind_o,
  output logic [3:0]         reply_dest_o,
  output logic [REPLY_W-1:0] reply_data_o
);
  cfg_t                 cfg;
  logic [NUM_SLOTS-1:0] sts;
  logic [NUM_SLOTS-1:0] hit;
  logic [NUM_SLOTS-1:0] op_known;
  logic                 to_me;

  cec_wake_regs i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .hit_i   (hit),
    .cfg_o   (cfg),
    .sts_o   (sts)
  );

  cec_wake_match i_match (
    .cfg_i      (cfg),
    .valid_i    (frm_valid_i),
    .hdr_i      (frm_hdr_i),
    .len_i      (frm_len_i),
    .opcode_i   (frm_opcode_i),
    .arg_i      (frm_arg_i),
    .to_me_o    (to_me),
    .op_known_o (op_known),
    .hit_o      (hit)
  );

  cec_wake_reply i_reply (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_i      (cfg),
    .valid_i    (frm_valid_i),
    .hdr_i      (frm_hdr_i),
    .len_i      (frm_len_i),
    .opcode_i   (frm_opcode_i),
    .to_me_i    (to_me),
    .op_known_i (|op_known),
    .valid_o    (reply_valid_o),
    .kind_o     (reply_kind_o),
    .dest_o     (reply_dest_o),
    .data_o     (reply_data_o)
  );

  assign wake_o = |sts;
endmodule

// File: rtl/cec_wake_chk.sv
module cec_wake_chk
  import cec_wake_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 reg_we_i,
  input logic [ADDR_W-1:0]    reg_addr_i,
  input logic                 frm_valid_i,
  input logic [7:0]           frm_hdr_i,
  input logic [LEN_W-1:0]     frm_len_i,
  input logic                 wake_o,
  input logic                 reply_valid_o,
  input logic [NUM_SLOTS-1:0] sts_i
);
  AST_SET_NEEDS_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts_i & ~$past(sts_i)) != '0) |-> $past(frm_valid_i)); // R2

  AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(sts_i) & ~sts_i) != '0) |-> $past(reg_we_i && reg_addr_i == A_STS)); // R6

  AST_DIRECTED_SLOTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts_i[3:0] & ~$past(sts_i[3:0])) != '0) |-> $past(frm_hdr_i[3:0]) != BCAST_LA); // R2

  AST_BCAST_SLOT_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_i[BCAST_SLOT] && !$past(sts_i[BCAST_SLOT]) && $past(frm_hdr_i[3:0]) == BCAST_LA)
      |-> $past(frm_len_i) == LEN_W'(BCAST_LEN)); // R4

  AST_WAKE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wake_o) |-> $past(reg_we_i)); // R7

  AST_NO_BCAST_REPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reply_valid_o |-> $past(frm_valid_i) && $past(frm_hdr_i[3:0]) != BCAST_LA); // R9

  AST_POLL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_valid_i && frm_len_i == '0) |=> !reply_valid_o); // R11
endmodule

bind cec_wake_filter cec_wake_chk i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_we_i      (reg_we_i),
  .reg_addr_i    (reg_addr_i),
  .frm_valid_i   (frm_valid_i),
  .frm_hdr_i     (frm_hdr_i),
  .frm_len_i     (frm_len_i),
  .wake_o        (wake_o),
  .reply_valid_o (reply_valid_o),
  .sts_i         (sts)
);

// File: tb/test_cec_wake_filter.sv
module test_cec_wake_filter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [4:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        frm_valid_i = 1'b0;
  logic [7:0]  frm_hdr_i = '0;
  logic [4:0]  frm_len_i = '0;
  logic [7:0]  frm_opcode_i = '0;
  logic [7:0]  frm_arg_i = '0;
  logic        wake_o, reply_valid_o;
  logic [1:0]  reply_kind_o;
  logic [3:0]  reply_dest_o;
  logic [23:0] reply_data_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench-side configuration copy
  logic [4:0]  m_en;
  logic [3:0]  m_la;
  logic        m_aen, m_ben, m_bc;
  logic [7:0]  m_op [5];
  logic [7:0]  m_arga, m_argb;
  logic [23:0] m_vid;
  logic [15:0] m_pa;
  logic [2:0]  m_rsn, m_ver;
  logic [7:0]  m_type;
  logic [4:0]  m_sts;
  // expected frame result
  logic [4:0]  e_hit;
  logic        e_rv;
  logic [1:0]  e_kind;
  logic [3:0]  e_dest;
  logic [23:0] e_data;

  always #2 clk_i = ~clk_i;

  cec_wake_filter i_cec_wake_filter (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    case (a)
      5'h00: m_en = d[4:0];
      5'h01: begin m_la = d[3:0]; m_aen = d[4]; m_ben = d[5]; m_bc = d[6]; end
      5'h02, 5'h03, 5'h04, 5'h05, 5'h06: m_op[a - 5'h02] = d;
      5'h07: m_arga = d;
      5'h08: m_argb = d;
      5'h09: m_vid[23:16] = d;
      5'h0A: m_vid[15:8] = d;
      5'h0B: m_vid[7:0] = d;
      5'h0C: m_pa[15:8] = d;
      5'h0D: m_pa[7:0] = d;
      5'h0E: begin m_rsn = d[2:0]; m_ver = d[5:3]; end
      5'h0F: m_type = d;
      5'h10: m_sts = m_sts & ~d[4:0];
      default: ;
    endcase
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic model(input logic [7:0] hdr, input logic [4:0] len, input logic [7:0] op, input logic [7:0] arg);
    logic bc, mine, known, aok;
    bc   = hdr[3:0] == 4'hF;
    mine = !bc && hdr[3:0] == m_la;
    aok  = (!m_aen && !m_ben) || (len >= 2 && ((m_aen && arg == m_arga) || (m_ben && arg == m_argb)));
    known = 1'b0;
    e_hit = '0;
    for (int k = 0; k < 5; k++) begin
      logic base;
      base = m_en[k] && len != 0 && op == m_op[k];
      known |= base;
      if (k == 4 && m_bc) e_hit[k] = base && bc && len == 3;
      else if (k == 2)    e_hit[k] = base && mine && aok;
      else                e_hit[k] = base && mine;
    end
    e_rv = 1'b0; e_kind = 2'd0; e_dest = hdr[7:4]; e_data = {8'h00, op, 5'b0, m_rsn};
    if (mine && len != 0) begin
      if (op == 8'h83)      begin e_rv = 1; e_kind = 2'd1; e_dest = 4'hF; e_data = {m_pa, m_type}; end
      else if (op == 8'h8C) begin e_rv = 1; e_kind = 2'd2; e_dest = 4'hF; e_data = m_vid; end
      else if (op == 8'h9F) begin e_rv = 1; e_kind = 2'd3; e_data = {16'h0, 5'b0, m_ver}; end
      else                  e_rv = !known;
    end
  endtask

  // drive one frame, check reply and status; clear status afterwards when cleanup set
  task automatic frame(input logic [7:0] hdr, input logic [4:0] len, input logic [7:0] op,
                       input logic [7:0] arg, input bit cleanup);
    logic [7:0] s;
    model(hdr, len, op, arg);
    @(negedge clk_i);
    frm_valid_i = 1'b1; frm_hdr_i = hdr; frm_len_i = len; frm_opcode_i = op; frm_arg_i = arg;
    @(negedge clk_i);
    frm_valid_i = 1'b0;
    m_sts = m_sts | e_hit;
    chk(reply_valid_o == e_rv, $sformatf("R8/R9/R11 reply_valid hdr=%h len=%0d op=%h", hdr, len, op),
        32'(reply_valid_o), 32'(e_rv));
    if (e_rv) begin
      chk(reply_kind_o == e_kind, $sformatf("R8/R10 kind op=%h", op), 32'(reply_kind_o), 32'(e_kind));
      chk(reply_dest_o == e_dest, $sformatf("R8/R10 dest op=%h", op), 32'(reply_dest_o), 32'(e_dest));
      chk(reply_data_o == e_data, $sformatf("R8/R10 data op=%h", op), 32'(reply_data_o), 32'(e_data));
    end
    rd(5'h10, s);
    chk(s[4:0] == m_sts, $sformatf("R2/R3/R4/R5 status hdr=%h len=%0d op=%h arg=%h", hdr, len, op, arg),
        32'(s), 32'(m_sts));
    chk(wake_o == (m_sts != 0), "R7 wake level", 32'(wake_o), 32'(m_sts != 0));
    if (cleanup && m_sts != 0) begin
      wr(5'h10, 8'h1F);
      chk(wake_o == 1'b0, "R6/R7 wake after clear", 32'(wake_o), 0);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [7:0] exp_rst [17];
    m_en = 5'h17; m_la = 0; m_aen = 1; m_ben = 1; m_bc = 1;
    m_op[0] = 8'h04; m_op[1] = 8'h0D; m_op[2] = 8'h44; m_op[3] = 8'h00; m_op[4] = 8'h82;
    m_arga = 8'h40; m_argb = 8'h6D; m_vid = 0; m_pa = 0; m_rsn = 1; m_ver = 5; m_type = 0; m_sts = 0;
    exp_rst = '{8'h17, 8'h70, 8'h04, 8'h0D, 8'h44, 8'h00, 8'h82, 8'h40, 8'h6D,
                8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h29, 8'h00, 8'h00};
    #10 rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: reset values
    for (int a = 0; a < 17; a++) begin
      rd(5'(a), r);
      chk(r == exp_rst[a], $sformatf("R1 reset reg %0h", a), 32'(r), 32'(exp_rst[a]));
    end
    rd(5'h11, r);
    chk(r == 8'h00, "R1 unmapped reads zero", 32'(r), 0);
    chk(wake_o == 1'b0 && reply_valid_o == 1'b0, "R1 outputs idle", 32'({wake_o, reply_valid_o}), 0);

    // full opcode sweep, directed to own address, defaults
    for (int o = 0; o < 256; o++) frame(8'h30, 5'd2, 8'(o), 8'h40, 1);
    // same sweep as broadcast: R9, R4 (len 3 hits slot 4 only on 0x82)
    for (int o = 0; o < 256; o++) frame(8'h3F, 5'd3, 8'(o), 8'h00, 1);

    // R3: operand sweeps under each enable combination
    for (int a = 0; a < 256; a++) frame(8'h50, 5'd2, 8'h44, 8'(a), 1);
    wr(5'h01, 8'h50);  // operand A only
    for (int a = 0; a < 256; a++) frame(8'h50, 5'd2, 8'h44, 8'(a), 1);
    wr(5'h01, 8'h60);  // operand B only
    for (int a = 0; a < 256; a++) frame(8'h50, 5'd2, 8'h44, 8'(a), 1);
    wr(5'h01, 8'h40);  // no operand check
    frame(8'h50, 5'd1, 8'h44, 8'h00, 1);
    wr(5'h01, 8'h70);
    frame(8'h50, 5'd1, 8'h44, 8'h40, 1);  // R3 operand missing

    // R4: broadcast length sweep and directed attempts
    for (int l = 0; l < 8; l++) frame(8'h4F, 5'(l), 8'h82, 8'h10, 1);
    frame(8'h40, 5'd3, 8'h82, 8'h10, 1);
    wr(5'h01, 8'h30);  // slot 4 no longer broadcast-only
    frame(8'h40, 5'd3, 8'h82, 8'h10, 1);
    frame(8'h4F, 5'd3, 8'h82, 8'h10, 1);
    wr(5'h01, 8'h70);

    // R5/R2: destination sweep with two own addresses
    for (int d = 0; d < 16; d++) frame(8'h10 | 8'(d), 5'd1, 8'h04, 8'h00, 1);
    wr(5'h01, 8'h75);
    for (int d = 0; d < 16; d++) frame(8'h20 | 8'(d), 5'd1, 8'h0D, 8'h00, 1);
    frame(8'h25, 5'd0, 8'h0D, 8'h00, 1);  // R5/R11 poll
    wr(5'h01, 8'h70);

    // R5/R8: disable slot 0, enable slot 3 with new opcode
    wr(5'h00, 8'h1E);
    frame(8'h30, 5'd1, 8'h04, 8'h00, 1);
    wr(5'h05, 8'h36);
    wr(5'h00, 8'h1F);
    frame(8'h30, 5'd1, 8'h36, 8'h00, 1);
    frame(8'h30, 5'd1, 8'h04, 8'h00, 1);

    // R10: payloads with programmed identity
    wr(5'h09, 8'hA1); wr(5'h0A, 8'hB2); wr(5'h0B, 8'hC3);
    wr(5'h0C, 8'h12); wr(5'h0D, 8'h34); wr(5'h0F, 8'h04);
    wr(5'h0E, 8'h1C);  // version 3, reason 4
    frame(8'h70, 5'd1, 8'h83, 8'h00, 1);
    frame(8'h70, 5'd1, 8'h8C, 8'h00, 1);
    frame(8'h70, 5'd1, 8'h9F, 8'h00, 1);
    frame(8'h70, 5'd1, 8'hAA, 8'h00, 1);

    // R11: pulse lasts one cycle
    frame(8'h30, 5'd1, 8'hAA, 8'h00, 1);
    @(negedge clk_i);
    chk(reply_valid_o == 1'b0, "R11 single pulse", 32'(reply_valid_o), 0);

    // R6: sticky, partial clear, set wins over same-cycle clear
    frame(8'h30, 5'd1, 8'h04, 8'h00, 0);
    wr(5'h10, 8'h02);
    rd(5'h10, r);
    chk(r == 8'h01, "R6 unrelated clear keeps bit", 32'(r), 1);
    chk(wake_o == 1'b1, "R7 wake held", 32'(wake_o), 1);
    @(negedge clk_i);
    frm_valid_i = 1; frm_hdr_i = 8'h30; frm_len_i = 1; frm_opcode_i = 8'h04;
    reg_we_i = 1; reg_addr_i = 5'h10; reg_wdata_i = 8'h01;
    @(negedge clk_i);
    frm_valid_i = 0; reg_we_i = 0;
    rd(5'h10, r);
    chk(r == 8'h01, "R6 set wins over clear", 32'(r), 1);
    wr(5'h10, 8'h01);
    rd(5'h10, r);
    chk(r == 8'h00 && wake_o == 1'b0, "R6/R7 cleared", 32'({r, 7'b0, wake_o}), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule